// File: doc/BRIEF.md
# Multi-Policy Shared Bus Arbiter

A central arbiter that decides which of several requesters may drive a single shared bus. Each requester has a private request line and a private grant line. A shared busy line, raised by whichever unit currently drives the bus, tells the arbiter whether the bus is in use. A new decision is made only while the bus is free. The result is a one-hot grant plus the binary index of the winner.

A two-bit mode input selects one of four ordering policies:

- **Fixed order.** Index 0 always wins.
- **Time-division slots.** Each index owns a slot of `SLICE_LEN` clocks in turn. A slot whose owner is silent is simply wasted.
- **Least-recently-served.** A ranked list of indices. The winner moves to the bottom of the list.
- **Rotating.** The search starts just after the last winner.

A change of mode takes effect only in an idle cycle. The same change restores the ranked list, the rotation reference and the slot timer to their start values.

The control is a three-state machine. The states are `ST_IDLE`, `ST_OFFER` and `ST_OWNED`.

- **`ST_IDLE` to `ST_OFFER`:** the bus is free, the mode is unchanged and some request is eligible. The winner is latched.
- **`ST_OFFER` to `ST_OWNED`:** busy rises.
- **`ST_OFFER` to `ST_IDLE`:** the winner withdraws its request before raising busy.
- **`ST_OWNED` to `ST_IDLE`:** busy falls.

`ST_IDLE` stays put in two cases: when busy is high, or when a mode change is being applied. The grant is asserted in `ST_OFFER` and in `ST_OWNED`.

Top module: `shared_bus_arb`

## Requirements
- R1: While reset is asserted, and on leaving it, `grant` is all zero, `grant_valid` is 0 and `grant_idx` is 0. On leaving reset, the active mode is fixed order, the ranked list is 0,1,...,N-1 from highest to lowest, and the rotation reference is N-1.
- R2: `grant` is zero or one-hot. When `grant_valid` is 1, bit `grant_idx` of `grant` is the only bit set. When `grant_valid` is 0, `grant` is zero and `grant_idx` is 0.
- R3: A grant is issued only at a clock edge where the arbiter is in `ST_IDLE`, `bus_busy` is 0 and the winner's request is 1. While `bus_busy` stays 1 in `ST_IDLE`, no grant is issued, whatever the requests. The grant appears in the cycle right after that edge.
- R4: Once issued, a grant holds with an unchanged index for as long as `bus_busy` is 1, even with the request dropped. It clears one cycle after `bus_busy` falls in `ST_OWNED`. It also clears one cycle after the owner drops its request in `ST_OFFER` without having raised `bus_busy`.
- R5: Mode encoding `mode_sel` = 0 is fixed order: the lowest requesting index wins.
- R6: Mode encoding 1 is time-division. The slot index starts at 0 on entry to the mode and advances by one, wrapping from N-1 to 0, every `SLICE_LEN` clock edges. At an arbitration edge, only the owner of the current slot can be granted.
- R7: In mode 1, a pending request from any index other than the current slot owner gets no grant, even when the slot owner is not requesting.
- R8: Mode encoding 2 is least-recently-served. The winner is the first requesting index in the ranked list, and the winner then moves to the lowest-priority end of the list.
- R9: Mode encoding 3 is rotating. The search starts at (reference + 1) modulo N and wraps around, and the winner becomes the new reference.
- R10: A new `mode_sel` value is taken at the first edge in `ST_IDLE` with `bus_busy` at 0. That edge issues no grant. Taking a new mode restores the ranked list to 0..N-1, the rotation reference to N-1, and the slot index and slot counter to 0.
- R11: With no request pending, no grant is issued. In mode 1, the slot index keeps advancing during such idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Policy: 0 fixed, 1 time-division, 2 least-recently-served, 3 rotating |
| req | input | NREQ | One request line per requester |
| bus_busy | input | 1 | Raised by the unit that currently drives the bus |
| grant | output | NREQ | One-hot grant |
| grant_valid | output | 1 | A grant is active |
| grant_idx | output | $clog2(NREQ) | Index of the granted requester, 0 when none |

## Verification
The bench builds the arbiter with four requesters and a slot length of three clocks. The non-power-of-two slot length checks that the slot counter wraps at a count that is not a natural binary boundary. Four requesters are enough to make the ranked list and the rotation reference each reach a state in which re-entering the mode with and without a reset gives different winners, so the reset on mode change can be observed at the grant port. The time-division checks follow the slot index through idle stretches and held transfers, so the bench's slot schedule has to match the arbiter's exactly.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_SLICE  = 2'd1,
        MODE_LRU    = 2'd2,
        MODE_ROTATE = 2'd3
    } arb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_OWNED = 2'd2
    } arb_state_e;

endpackage

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
    parameter int NREQ      = 4,
    parameter int SLICE_LEN = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 run,
    input  logic                                 clear,
    output logic [(NREQ > 1 ? $clog2(NREQ) : 1)-1:0] slot
);
    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int CNTW = (SLICE_LEN > 1) ? $clog2(SLICE_LEN) : 1;
    localparam logic [CNTW-1:0] CNT_LAST  = CNTW'(SLICE_LEN - 1);
    localparam logic [IDXW-1:0] SLOT_LAST = IDXW'(NREQ - 1);

    logic [CNTW-1:0] cnt_q;
    logic [IDXW-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (clear) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (run) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q  <= '0;
                slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign slot = slot_q;

    // R6
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(slot_q) < NREQ) && (int'(cnt_q) < SLICE_LEN));

    // R6
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && cnt_q != CNT_LAST) |=> $stable(slot_q));

endmodule

// File: rtl/arb_lru_list.sv
module arb_lru_list #(
    parameter int NREQ = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        clear,
    input  logic                                        upd,
    input  logic [(NREQ > 1 ? $clog2(NREQ) : 1)-1:0]        upd_idx,
    output logic [NREQ*(NREQ > 1 ? $clog2(NREQ) : 1)-1:0]   order_flat
);
    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [IDXW-1:0] rank_q [NREQ];
    logic [IDXW-1:0] rank_d [NREQ];
    logic [NREQ-1:0] present;

    always_comb begin
        int pos;
        pos = 0;
        for (int p = 0; p < NREQ; p++) begin
            if (rank_q[p] == upd_idx) pos = p;
        end
        for (int q = 0; q < NREQ; q++) begin
            if (q < pos)            rank_d[q] = rank_q[q];
            else if (q < NREQ - 1)  rank_d[q] = rank_q[q + 1];
            else                    rank_d[q] = upd_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREQ; i++) rank_q[i] <= IDXW'(i);
        end else if (clear) begin
            for (int i = 0; i < NREQ; i++) rank_q[i] <= IDXW'(i);
        end else if (upd) begin
            for (int i = 0; i < NREQ; i++) rank_q[i] <= rank_d[i];
        end
    end

    generate
        for (genvar g = 0; g < NREQ; g++) begin : g_flat
            assign order_flat[g*IDXW +: IDXW] = rank_q[g];
        end
    endgenerate

    always_comb begin
        present = '0;
        for (int p = 0; p < NREQ; p++) present[rank_q[p]] = 1'b1;
    end

    // R8
    lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(present) == NREQ);

    // R8
    lru_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clear) |=> rank_q[NREQ-1] == $past(upd_idx));

endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int NREQ = 4
) (
    input  arb_mode_e                                      mode,
    input  logic [NREQ-1:0]                                req,
    input  logic [(NREQ > 1 ? $clog2(NREQ) : 1)-1:0]        rot_ref,
    input  logic [(NREQ > 1 ? $clog2(NREQ) : 1)-1:0]        slot,
    input  logic [NREQ*(NREQ > 1 ? $clog2(NREQ) : 1)-1:0]   order_flat,
    output logic                                           win_valid,
    output logic [(NREQ > 1 ? $clog2(NREQ) : 1)-1:0]        win_idx
);
    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [IDXW-1:0] rank [NREQ];

    generate
        for (genvar g = 0; g < NREQ; g++) begin : g_unflat
            assign rank[g] = order_flat[g*IDXW +: IDXW];
        end
    endgenerate

    always_comb begin
        int cand;
        win_valid = 1'b0;
        win_idx   = '0;
        cand      = 0;
        unique case (mode)
            MODE_FIXED: begin
                for (int i = NREQ - 1; i >= 0; i--) begin
                    if (req[i]) begin
                        win_valid = 1'b1;
                        win_idx   = IDXW'(i);
                    end
                end
            end
            MODE_SLICE: begin
                if (req[slot]) begin
                    win_valid = 1'b1;
                    win_idx   = slot;
                end
            end
            MODE_LRU: begin
                for (int p = NREQ - 1; p >= 0; p--) begin
                    if (req[rank[p]]) begin
                        win_valid = 1'b1;
                        win_idx   = rank[p];
                    end
                end
            end
            MODE_ROTATE: begin
                for (int k = NREQ; k >= 1; k--) begin
                    cand = int'(rot_ref) + k;
                    if (cand >= NREQ) cand = cand - NREQ;
                    if (req[cand]) begin
                        win_valid = 1'b1;
                        win_idx   = IDXW'(cand);
                    end
                end
            end
            default: begin
                win_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shared_bus_arb.sv
module shared_bus_arb
    import arb_pkg::*;
#(
    parameter int NREQ      = 4,
    parameter int SLICE_LEN = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [1:0]                              mode_sel,
    input  logic [NREQ-1:0]                         req,
    input  logic                                    bus_busy,
    output logic [NREQ-1:0]                         grant,
    output logic                                    grant_valid,
    output logic [(NREQ > 1 ? $clog2(NREQ) : 1)-1:0] grant_idx
);
    localparam int IDXW = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam logic [IDXW-1:0] REF_START = IDXW'(NREQ - 1);

    arb_state_e      state_q, state_d;
    arb_mode_e       mode_q;
    arb_mode_e       mode_in;
    logic [IDXW-1:0] owner_q;
    logic [IDXW-1:0] rot_ref_q;
    logic [IDXW-1:0] slot;
    logic [IDXW-1:0] win_idx;
    logic            win_valid;
    logic [NREQ*IDXW-1:0] order_flat;
    logic            mode_switch;
    logic            take;

    assign mode_in     = arb_mode_e'(mode_sel);
    assign mode_switch = (state_q == ST_IDLE) && !bus_busy && (mode_in != mode_q);
    assign take        = (state_q == ST_IDLE) && !bus_busy && !mode_switch && win_valid;

    arb_slot_timer #(.NREQ(NREQ), .SLICE_LEN(SLICE_LEN)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode_q == MODE_SLICE),
        .clear (mode_switch),
        .slot  (slot)
    );

    arb_lru_list #(.NREQ(NREQ)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (mode_switch),
        .upd        (take && (mode_q == MODE_LRU)),
        .upd_idx    (win_idx),
        .order_flat (order_flat)
    );

    arb_pick #(.NREQ(NREQ)) u_pick (
        .mode       (mode_q),
        .req        (req),
        .rot_ref    (rot_ref_q),
        .slot       (slot),
        .order_flat (order_flat),
        .win_valid  (win_valid),
        .win_idx    (win_idx)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_OFFER;
            ST_OFFER: begin
                if (bus_busy)          state_d = ST_OWNED;
                else if (!req[owner_q]) state_d = ST_IDLE;
            end
            ST_OWNED: if (!bus_busy) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and arbitration context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_FIXED;
            owner_q   <= '0;
            rot_ref_q <= REF_START;
        end else begin
            state_q <= state_d;
            if (mode_switch) begin
                mode_q    <= mode_in;
                rot_ref_q <= REF_START;
            end
            if (take) begin
                owner_q <= win_idx;
                if (mode_q == MODE_ROTATE) rot_ref_q <= win_idx;
            end
        end
    end

    // outputs
    always_comb begin
        grant       = '0;
        grant_valid = (state_q != ST_IDLE);
        grant_idx   = grant_valid ? owner_q : '0;
        if (grant_valid) grant[owner_q] = 1'b1;
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> $past(!bus_busy));

    // R3
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (($past(req) & grant) != '0));

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && bus_busy) |=> (grant_valid && $stable(grant_idx)));

    // R5
    fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_valid) && mode_q == MODE_FIXED) |-> (($past(req) & (grant - 1'b1)) == '0));

    // R10
    switch_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_switch |=> !grant_valid);

endmodule

// File: tb/shared_bus_arb_bench.sv
module shared_bus_arb_bench;
    localparam int NREQ = 4;
    localparam int SL   = 3;
    localparam int IDXW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      mode_sel;
    logic [NREQ-1:0] req;
    logic            bus_busy;
    logic [NREQ-1:0] grant;
    logic            grant_valid;
    logic [IDXW-1:0] grant_idx;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int base   = 0;
    logic [1:0] cur_mode;
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shared_bus_arb #(.NREQ(NREQ), .SLICE_LEN(SL)) u_shared_bus_arb (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .req(req),
        .bus_busy(bus_busy), .grant(grant), .grant_valid(grant_valid),
        .grant_idx(grant_idx)
    );

    // {mode[8:7], req[6:3], exp_valid[2], exp_idx[1:0]}
    localparam logic [8:0] VEC [22] = '{
        {2'd0, 4'b1111, 1'b1, 2'd0},
        {2'd0, 4'b1110, 1'b1, 2'd1},
        {2'd0, 4'b1100, 1'b1, 2'd2},
        {2'd0, 4'b1000, 1'b1, 2'd3},
        {2'd0, 4'b0000, 1'b0, 2'd0},
        {2'd0, 4'b1010, 1'b1, 2'd1},
        {2'd0, 4'b0110, 1'b1, 2'd1},
        {2'd2, 4'b1111, 1'b1, 2'd0},
        {2'd2, 4'b1111, 1'b1, 2'd1},
        {2'd2, 4'b0011, 1'b1, 2'd0},
        {2'd2, 4'b0101, 1'b1, 2'd2},
        {2'd2, 4'b0111, 1'b1, 2'd1},
        {2'd2, 4'b1010, 1'b1, 2'd3},
        {2'd3, 4'b1111, 1'b1, 2'd0},
        {2'd3, 4'b1111, 1'b1, 2'd1},
        {2'd3, 4'b1001, 1'b1, 2'd3},
        {2'd3, 4'b1111, 1'b1, 2'd0},
        {2'd3, 4'b0110, 1'b1, 2'd1},
        {2'd3, 4'b0100, 1'b1, 2'd2},
        {2'd0, 4'b1001, 1'b1, 2'd0},
        {2'd2, 4'b0110, 1'b1, 2'd1},
        {2'd3, 4'b1100, 1'b1, 2'd2}
    };

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_grant(input string tag, input bit ev, input int ei);
        check(tag, int'(grant_valid), int'(ev));
        if (ev) begin
            check(tag, int'(grant_idx), ei);
            check(tag, int'(grant), 1 << ei);
        end else begin
            check(tag, int'(grant), 0);
        end
    endtask

    // called at a negedge while a grant is active
    task automatic release_bus();
        bus_busy = 1'b1;
        req      = '0;
        @(negedge clk);
        bus_busy = 1'b0;
        @(negedge clk);
        check("R4 cleared after busy falls", int'(grant_valid), 0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_sel = m;
        req      = '0;
        @(negedge clk);
        base     = cyc;
        cur_mode = m;
    endtask

    task automatic tdm_run(input logic [NREQ-1:0] rv);
        req = rv;
        for (int n = 0; n < 20; n++) begin
            int s;
            bit ev;
            s  = ((cyc - base) / SL) % NREQ;
            ev = rv[s];
            @(negedge clk);
            check_grant(ev ? "R6 slot owner granted" : "R7 non-owner idle", ev, s);
            if (ev || grant_valid) begin
                if (grant_valid) release_bus();
                break;
            end
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m, input int i);
        if (i >= 19) return "R10 mode re-entry restarts order";
        case (m)
            2'd0:    return "R5 fixed order";
            2'd2:    return "R8 least recently served";
            default: return "R9 rotating";
        endcase
    endfunction

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        mode_sel = 2'd0;
        req      = '0;
        bus_busy = 1'b0;
        cur_mode = 2'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_grant("R1 reset state", 1'b0, 0);
        check("R1 idx zero", int'(grant_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_grant("R1 after reset", 1'b0, 0);

        // R3: no grant while the bus is busy
        bus_busy = 1'b1;
        req      = 4'b1111;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_grant("R3 busy blocks grant", 1'b0, 0);
        end
        bus_busy = 1'b0;
        @(negedge clk);
        check_grant("R3 grant once idle", 1'b1, 0);
        release_bus();

        // R4: hold through acknowledge, drop on withdraw
        req = 4'b0100;
        @(negedge clk);
        check_grant("R2 grant to index 2", 1'b1, 2);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check_grant("R4 offer held", 1'b1, 2);
        end
        bus_busy = 1'b1;
        req      = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_grant("R4 held while busy", 1'b1, 2);
        end
        bus_busy = 1'b0;
        @(negedge clk);
        check_grant("R4 release on busy fall", 1'b0, 0);
        req = 4'b0001;
        @(negedge clk);
        check_grant("R4 offer to index 0", 1'b1, 0);
        req = '0;
        @(negedge clk);
        check_grant("R4 withdraw clears", 1'b0, 0);

        // R10: mode change deferred until idle, change cycle grants nothing
        req = 4'b0100;
        @(negedge clk);
        check_grant("R10 setup grant", 1'b1, 2);
        bus_busy = 1'b1;
        req      = 4'b1111;
        mode_sel = 2'd2;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check_grant("R10 no change while busy", 1'b1, 2);
        end
        bus_busy = 1'b0;
        @(negedge clk);
        check_grant("R10 release", 1'b0, 0);
        @(negedge clk);
        check_grant("R10 switch cycle no grant", 1'b0, 0);
        @(negedge clk);
        check_grant("R10 first grant in new mode", 1'b1, 0);
        cur_mode = 2'd2;
        release_bus();

        // table walk
        for (int i = 0; i < 22; i++) begin
            logic [1:0] m;
            m = VEC[i][8:7];
            if (m != cur_mode || i == 20 || i == 21) begin
                if (m == cur_mode) set_mode(2'd1);
                set_mode(m);
            end
            req = VEC[i][6:3];
            @(negedge clk);
            check_grant(mode_tag(m, i), VEC[i][2], int'(VEC[i][1:0]));
            if (grant_valid) release_bus();
            else req = '0;
        end

        // time-division mode
        set_mode(2'd0);
        set_mode(2'd1);
        tdm_run(4'b0010);
        tdm_run(4'b0100);
        req = '0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_grant("R11 no request no grant", 1'b0, 0);
        end
        tdm_run(4'b1001);
        tdm_run(4'b1000);
        tdm_run(4'b0001);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule